// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This unit resolves the register-indirect branch instructions of a 32-bit processor. The unit receives the decoded opcode and the 3-bit condition field of the instruction. It also receives the register value that holds the branch target (rb), the register value that is tested (rc) and the program counter, which has already been advanced past the current instruction. From these it produces four results: whether the branch is taken, the next program counter, and a write request that copies the program counter into the link register (ra).

Two opcodes are handled. Opcode 8 is a plain conditional branch. Opcode 9 is the linking variant: it always writes the incoming program counter to the link register, including when its condition selects "never branch". Every other opcode passes through without effect: no branch is taken, no link write is made, and the next program counter equals the incoming one. The register file sits outside the unit, so the link write appears only as an enable and a data word.

The results leave the unit through an optional output register, which is on by default. With it, each result appears one clock after its inputs. A valid strobe travels alongside the results.

Top module: `brlink_unit`

## Requirements
- R1: A branch is taken only when `in_valid` is high and `opcode` equals 8 or 9. Any other opcode, or `in_valid` low, gives `take`=0 and `link_we`=0.
- R2: Condition field `cond`=3'b000 never branches, and `cond`=3'b001 always branches.
- R3: `cond`=3'b010 branches when `operand` equals zero, and `cond`=3'b011 branches when `operand` is nonzero.
- R4: `cond`=3'b100 branches when bit 31 (the top bit) of `operand` is clear. `cond`=3'b101 branches when that bit is set.
- R5: The reserved codes `cond`=3'b110 and 3'b111 never branch.
- R6: When `take`=1, `next_pc` equals `target`. Otherwise `next_pc` equals `pc_in`.
- R7: For opcode 9 with `in_valid` high, `link_we`=1 and `link_data`=`pc_in`, whatever the condition and its outcome.
- R8: For opcode 8, `link_we` stays 0.
- R9: With the default output register, every result and `out_valid` appear exactly one clock after the inputs that produced them. While `rst_n` is low, `out_valid`, `take` and `link_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 5 | Instruction opcode |
| cond | input | 3 | Branch condition field |
| target | input | 32 | rb register value, used as the branch target |
| operand | input | 32 | rc register value, the tested operand |
| pc_in | input | 32 | Program counter, already incremented |
| out_valid | output | 1 | Results below belong to a presented instruction |
| take | output | 1 | Branch is taken |
| next_pc | output | 32 | Program counter to load |
| link_we | output | 1 | Write the link register |
| link_data | output | 32 | Value for the link register |

## Verification
Every result of this unit is due one rising edge after its inputs are presented. This holds for the taken flag, the next program counter, the link enable and data, and the valid strobe.

The bench drives a new instruction on each falling edge and records the expected results in a queue. On the next falling edge it pops that entry and compares all five outputs, so each check lands exactly one register stage after its stimulus.

The bound checker uses its own one-stage delay of the inputs. It relates those delayed inputs to the outputs in the same cycle.

// File: rtl/brlink_pkg.sv
package brlink_pkg;

   // Opcodes of the two branch forms
   localparam int unsigned OPC_BRANCH = 8;
   localparam int unsigned OPC_BRLINK = 9;

   // Branch condition codes
   typedef enum logic [2:0] {
      CND_NEVER   = 3'b000,
      CND_ALWAYS  = 3'b001,
      CND_ZERO    = 3'b010,
      CND_NONZERO = 3'b011,
      CND_PLUS    = 3'b100,
      CND_MINUS   = 3'b101,
      CND_RSV6    = 3'b110,
      CND_RSV7    = 3'b111
   } cond_e;

   localparam int unsigned COND_W = 3;

endpackage

// File: rtl/brlink_decode.sv
module brlink_decode #(
   parameter int unsigned OPC_W = 5
) (
   input  logic             in_valid,
   input  logic [OPC_W-1:0] opcode,
   output logic             is_branch,
   output logic             is_link
);
   import brlink_pkg::*;

   localparam logic [OPC_W-1:0] OP_B  = OPC_W'(OPC_BRANCH);
   localparam logic [OPC_W-1:0] OP_BL = OPC_W'(OPC_BRLINK);

   generate
      if (OPC_W < 4) begin : g_bad_w
         $error("brlink_decode: OPC_W must hold opcode 9");
      end
   endgenerate

   always_comb begin
      is_link   = in_valid && (opcode == OP_BL);
      is_branch = in_valid && ((opcode == OP_B) || (opcode == OP_BL));
   end

endmodule

// File: rtl/brlink_cond_eval.sv
module brlink_cond_eval #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8
) (
   input  logic [2:0]        cond,
   input  logic [DATA_W-1:0] operand,
   output logic              cond_met
);
   import brlink_pkg::*;

   localparam int unsigned NUM_LANES = (DATA_W + LANE_W - 1) / LANE_W;
   localparam int unsigned PAD_W     = NUM_LANES * LANE_W;
   localparam int unsigned SIGN_BIT  = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("brlink_cond_eval: DATA_W must be at least 2");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("brlink_cond_eval: LANE_W must be at least 1");
      end
   endgenerate

   logic [PAD_W-1:0]     padded;
   logic [NUM_LANES-1:0] lane_any;
   logic                 is_zero;
   logic                 is_neg;

   always_comb begin
      padded = '0;
      padded[DATA_W-1:0] = operand;
   end

   // Zero detect split into lanes so the OR tree is balanced per slice
   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         assign lane_any[g] = |padded[g*LANE_W +: LANE_W];
      end
   endgenerate

   assign is_zero = ~|lane_any;
   assign is_neg  = operand[SIGN_BIT];

   always_comb begin
      unique case (cond_e'(cond))
         CND_ALWAYS:  cond_met = 1'b1;
         CND_ZERO:    cond_met = is_zero;
         CND_NONZERO: cond_met = ~is_zero;
         CND_PLUS:    cond_met = ~is_neg;
         CND_MINUS:   cond_met = is_neg;
         default:     cond_met = 1'b0;
      endcase
   end

endmodule

// File: rtl/brlink_pc_select.sv
module brlink_pc_select #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              is_branch,
   input  logic              is_link,
   input  logic              cond_met,
   input  logic [ADDR_W-1:0] target,
   input  logic [ADDR_W-1:0] pc_in,
   output logic              take,
   output logic [ADDR_W-1:0] next_pc,
   output logic              link_we,
   output logic [ADDR_W-1:0] link_data
);

   always_comb begin
      take      = is_branch & cond_met;
      next_pc   = take ? target : pc_in;
      link_we   = is_link;
      link_data = pc_in;
   end

endmodule

// File: rtl/brlink_unit.sv
module brlink_unit #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned OPC_W   = 5,
   parameter int unsigned LANE_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [2:0]        cond,
   input  logic [DATA_W-1:0] target,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] pc_in,
   output logic              out_valid,
   output logic              take,
   output logic [DATA_W-1:0] next_pc,
   output logic              link_we,
   output logic [DATA_W-1:0] link_data
);

   logic              is_branch;
   logic              is_link;
   logic              cond_met;
   logic              c_take;
   logic              c_link_we;
   logic [DATA_W-1:0] c_next_pc;
   logic [DATA_W-1:0] c_link_data;

   brlink_decode #(.OPC_W(OPC_W)) u_decode (
      .in_valid  (in_valid),
      .opcode    (opcode),
      .is_branch (is_branch),
      .is_link   (is_link)
   );

   brlink_cond_eval #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cond (
      .cond     (cond),
      .operand  (operand),
      .cond_met (cond_met)
   );

   brlink_pc_select #(.ADDR_W(DATA_W)) u_sel (
      .is_branch (is_branch),
      .is_link   (is_link),
      .cond_met  (cond_met),
      .target    (target),
      .pc_in     (pc_in),
      .take      (c_take),
      .next_pc   (c_next_pc),
      .link_we   (c_link_we),
      .link_data (c_link_data)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               take      <= 1'b0;
               link_we   <= 1'b0;
               next_pc   <= '0;
               link_data <= '0;
            end else begin
               out_valid <= in_valid;
               take      <= c_take;
               link_we   <= c_link_we;
               next_pc   <= c_next_pc;
               link_data <= c_link_data;
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid;
         assign take      = c_take;
         assign link_we   = c_link_we;
         assign next_pc   = c_next_pc;
         assign link_data = c_link_data;
      end
   endgenerate

endmodule

// File: rtl/brlink_unit_chk.sv
module brlink_unit_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned OPC_W   = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OPC_W-1:0]  opcode,
   input logic [2:0]        cond,
   input logic [DATA_W-1:0] target,
   input logic [DATA_W-1:0] operand,
   input logic [DATA_W-1:0] pc_in,
   input logic              out_valid,
   input logic              take,
   input logic [DATA_W-1:0] next_pc,
   input logic              link_we,
   input logic [DATA_W-1:0] link_data
);

   logic              d_valid;
   logic [OPC_W-1:0]  d_op;
   logic [2:0]        d_cond;
   logic [DATA_W-1:0] d_tgt;
   logic [DATA_W-1:0] d_opnd;
   logic [DATA_W-1:0] d_pc;

   generate
      if (OUT_REG) begin : g_dly
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               d_valid <= 1'b0;
               d_op    <= '0;
               d_cond  <= '0;
               d_tgt   <= '0;
               d_opnd  <= '0;
               d_pc    <= '0;
            end else begin
               d_valid <= in_valid;
               d_op    <= opcode;
               d_cond  <= cond;
               d_tgt   <= target;
               d_opnd  <= operand;
               d_pc    <= pc_in;
            end
         end
      end else begin : g_nodly
         assign d_valid = in_valid;
         assign d_op    = opcode;
         assign d_cond  = cond;
         assign d_tgt   = target;
         assign d_opnd  = operand;
         assign d_pc    = pc_in;
      end
   endgenerate

   logic d_br;
   logic d_bl;
   assign d_bl = d_valid && (d_op == OPC_W'(9));
   assign d_br = d_valid && ((d_op == OPC_W'(8)) || d_bl);

   p_take_only_branch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> d_br);
   p_nolink_nonbranch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !d_br |-> !link_we);
   p_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (d_cond == 3'b000) |-> !take);
   p_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (d_br && d_cond == 3'b001) |-> take);
   p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (d_br && d_cond == 3'b010) |-> (take == (d_opnd == '0)));
   p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (d_br && d_cond == 3'b011) |-> (take == (d_opnd != '0)));
   p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_br && d_cond[2:1] == 2'b10) |-> (take == (d_opnd[DATA_W-1] == d_cond[0])));
   p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_cond[2:1] == 2'b11) |-> !take);
   p_pc_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (next_pc == d_tgt));
   p_pc_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !take) |-> (next_pc == d_pc));
   p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
      d_bl |-> (link_we && link_data == d_pc));
   p_nolink_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && d_op == OPC_W'(8)) |-> !link_we);
   p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == d_valid);

endmodule

bind brlink_unit brlink_unit_chk #(
   .DATA_W  (DATA_W),
   .OPC_W   (OPC_W),
   .OUT_REG (OUT_REG)
) u_chk (.*);

// File: tb/brlink_unit_test.sv
`timescale 1ns/1ps
module brlink_unit_test;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [4:0]    opcode = '0;
   logic [2:0]    cond = '0;
   logic [W-1:0]  target = '0;
   logic [W-1:0]  operand = '0;
   logic [W-1:0]  pc_in = '0;
   logic          out_valid;
   logic          take;
   logic [W-1:0]  next_pc;
   logic          link_we;
   logic [W-1:0]  link_data;

   always #10 clk = ~clk;   // 50 MHz

   brlink_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .cond(cond), .target(target), .operand(operand), .pc_in(pc_in),
      .out_valid(out_valid), .take(take), .next_pc(next_pc),
      .link_we(link_we), .link_data(link_data)
   );

   typedef struct {
      bit           v;
      bit           tk;
      logic [W-1:0] npc;
      bit           lwe;
      logic [W-1:0] ldat;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 0;

   // Behavioural reference
   function automatic exp_t model(bit v, int op, int c, logic [W-1:0] tg,
                                  logic [W-1:0] opd, logic [W-1:0] pc);
      exp_t e;
      bit   br = v && (op == 8 || op == 9);
      bit   met;
      string t;
      case (c)
         0: begin met = 0; t = "R2"; end
         1: begin met = 1; t = "R2"; end
         2: begin met = (opd == 0); t = "R3"; end
         3: begin met = (opd != 0); t = "R3"; end
         4: begin met = (opd[W-1] == 1'b0); t = "R4"; end
         5: begin met = (opd[W-1] == 1'b1); t = "R4"; end
         default: begin met = 0; t = "R5"; end
      endcase
      if (!br) t = "R1";
      e.v    = v;
      e.tk   = br && met;
      e.npc  = e.tk ? tg : pc;
      e.lwe  = v && (op == 9);
      e.ldat = pc;
      e.tag  = t;
      return e;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic compare();
      exp_t e;
      if (exp_q.size() == 0) return;
      e = exp_q.pop_front();
      chk(out_valid == e.v, "R9", "out_valid", W'(out_valid), W'(e.v));
      chk(take == e.tk, e.tag, "take", W'(take), W'(e.tk));
      chk(next_pc == e.npc, "R6", "next_pc", next_pc, e.npc);
      chk(link_we == e.lwe, (e.v && opcode == 5'd8) ? "R8" : "R7", "link_we", W'(link_we), W'(e.lwe));
      if (e.lwe) chk(link_data == e.ldat, "R7", "link_data", link_data, e.ldat);
   endtask

   // Called on a falling edge: check previous vector, then apply new one
   task automatic step(bit v, int op, int c, logic [W-1:0] tg,
                       logic [W-1:0] opd, logic [W-1:0] pc);
      compare();
      in_valid = v; opcode = op[4:0]; cond = c[2:0];
      target = tg; operand = opd; pc_in = pc;
      exp_q.push_back(model(v, op, c, tg, opd, pc));
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] vals[5];
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
      vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF;

      // Reset state, R9
      in_valid = 1'b1; opcode = 5'd9; cond = 3'd1;
      target = 32'h1234; pc_in = 32'h40;
      repeat (3) @(negedge clk);
      chk(out_valid == 0, "R9", "reset out_valid", W'(out_valid), 0);
      chk(take == 0, "R9", "reset take", W'(take), 0);
      chk(link_we == 0, "R9", "reset link_we", W'(link_we), 0);
      rst_n = 1'b1;

      // Exhaustive directed: both branch opcodes, all conditions, edge operands
      for (int op = 8; op <= 9; op++)
         for (int c = 0; c < 8; c++)
            for (int k = 0; k < 5; k++)
               step(1, op, c, 32'hA000_0000 + W'(c*16 + k), vals[k], 32'h0000_1000 + W'(op*256 + c*8 + k));

      // Non-branch opcodes: R1
      for (int op = 0; op < 32; op++)
         if (op != 8 && op != 9) step(1, op, 1, 32'hDEAD_0000, 0, 32'h2000 + W'(op));

      // Idle slots with branch opcode present: R1, R9
      step(0, 9, 1, 32'h5555, 0, 32'h6666);
      step(0, 8, 1, 32'h5555, 0, 32'h6666);
      step(1, 9, 0, 32'h7777, 0, 32'h8888);   // link but never branch, R7

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         int op;
         int sel = $urandom_range(0, 3);
         op = (sel == 0) ? 8 : (sel == 1) ? 9 : $urandom_range(0, 31);
         step($urandom_range(0, 7) != 0, op, $urandom_range(0, 7),
              $urandom, ($urandom_range(0, 3) == 0) ? 0 : $urandom, $urandom);
      end
      step(0, 0, 0, 0, 0, 0);
      compare();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule